// File: doc/BRIEF.md
# Type-C Lane Crossbar Control Register Bank

This block is the digital control side of a Type-C high-speed lane crossbar. It is an I2C target that answers at one 7-bit address and holds a small bank of byte-wide registers. A controller first writes a register pointer, then any number of data bytes, and the pointer steps forward after each byte. Reads work the same way, usually after a pointer write and a repeated START.

From the register contents it drives the crossbar's control lines: a 2-bit source select for each of four connector-side lane paths, the orientation swap flag, the output swing and DC-gain code, the data role, and a 4-bit transmit and receive equalization code for each of two upstream and two downstream channels. Override bits choose between register values and pin-strapped defaults. New settings reach the outputs together at the STOP that ends a write, so a multi-byte update never shows a half-written state on the lanes.

SCL and SDA are sampled with the system clock, which must run at least about eight times faster than SCL. SDA is open drain: `sda_oe` high pulls the line low.

Top module: `tc_lane_ctrl`

## Requirements
- R1: The target acknowledges only the 7-bit address 0x12 (parameter); any other address gets no ACK and the transaction has no effect. The target pulls SDA low only while SCL is low.
- R2: In a write, the first byte after the address loads the register pointer and each further byte is stored at the pointer, which then increments by one. A read returns the byte at the pointer and then increments it. Defined registers are 0x0A, 0x0B, 0x0C, 0x10, 0x11, 0x12, 0x13, 0x20, 0x21, 0x22 and 0x23; they read back what was written.
- R3: Any other pointer value, and 0x1B, reads as 0x00. Writes there are not stored but are still acknowledged, and the pointer still increments.
- R4: Register 0x0A bits [1:0] set the mode. `lane_sel_o` holds four 2-bit fields, path i at bits [2i+1:2i], with code 0 off, 1 USB, 2 video. Paths 0 and 1 form pair A, paths 2 and 3 pair B. Unflipped: mode 0 gives A off and B off; mode 1 A USB and B off; mode 2 A video and B video; mode 3 A USB and B video. Code 3 never appears.
- R5: Register 0x0A bit 2 swaps the pair A and pair B assignments of R4 and drives `flip_o`. Nothing else changes.
- R6: When register 0x0A bit 4 is 1, `eq_o` bytes [7:0], [15:8], [23:16] and [31:24] are registers 0x10, 0x11, 0x20 and 0x21, each byte being {tx[7:4], rx[3:0]}. When the bit is 0, every upstream nibble (bits [15:0]) is `strap_ueq_i` and every downstream nibble (bits [31:16]) is `strap_deq_i`.
- R7: When register 0x0C bit 6 is 1, `swing_o` is register 0x0C bits [5:2]; otherwise it is `strap_swing_i`. `role_o` is register 0x0C bits [1:0].
- R8: Writing a byte with bit 0 set to 0x1B resets every register to 0x00. A byte with bit 0 clear has no effect.
- R9: The R4 to R7 outputs use values captured at the STOP that ends a write holding at least one data byte to this target. They do not change mid-transaction.
- R10: After reset all registers read 0x00, all lanes are off, no flip, and swing and EQ follow the straps with role 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | High to pull SDA low |
| strap_swing_i | input | 4 | Pin-strapped swing and DC-gain code |
| strap_ueq_i | input | 4 | Pin-strapped upstream EQ code |
| strap_deq_i | input | 4 | Pin-strapped downstream EQ code |
| lane_sel_o | output | 8 | Source select per connector lane path |
| flip_o | output | 1 | Orientation swap in effect |
| swing_o | output | 4 | Output swing and DC-gain code |
| role_o | output | 2 | Data role select |
| eq_o | output | 32 | TX and RX EQ codes for the four channels |

## Verification
A corrupted stored register shows up at the next read of that address, and after the next write STOP it also reaches the lane, flip, swing or EQ outputs. A wrong pointer step shows up on the second byte of any multi-byte access. Faults in the capture path show up as lane selects that move before the STOP or fail to move after it, so the bench samples just before the STOP and a few cycles after it. A wrong bit-phase in the bus logic corrupts the very first ACK or read bit of a transaction.

// File: rtl/tc_lane_ctrl.sv
module tc_lane_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [3:0]  strap_swing_i,
  input  logic [3:0]  strap_ueq_i,
  input  logic [3:0]  strap_deq_i,
  output logic [7:0]  lane_sel_o,
  output logic        flip_o,
  output logic [3:0]  swing_o,
  output logic [1:0]  role_o,
  output logic [31:0] eq_o
);

  localparam logic [1:0] L_OFF = 2'd0, L_USB = 2'd1, L_VID = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK} st_t;

  logic [2:0] scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];

  st_t        state;
  logic [3:0] bitcnt;
  logic [7:0] shift, ptr, rbyte, rd_val;
  logic       rnw, need_ptr, nack, wr_seen;
  logic       wr_en, soft_rst, load_rd;

  logic [7:0] r_g1, r_g2, r_g3, r_u1, r_u2, r_x1, r_x2, r_d1, r_d2, r_misc, r_los;

  assign wr_en    = (state == S_WDAT) && scl_fall && (bitcnt == 4'd8) && !need_ptr;
  assign soft_rst = wr_en && (ptr == 8'h1B) && shift[0];
  assign load_rd  = scl_fall && ((state == S_AACK && rnw) || (state == S_RACK && !nack));

  always_comb begin
    case (ptr)
      8'h0A:   rd_val = r_g1;
      8'h0B:   rd_val = r_g2;
      8'h0C:   rd_val = r_g3;
      8'h10:   rd_val = r_u1;
      8'h11:   rd_val = r_u2;
      8'h12:   rd_val = r_x1;
      8'h13:   rd_val = r_x2;
      8'h20:   rd_val = r_d1;
      8'h21:   rd_val = r_d2;
      8'h22:   rd_val = r_misc;
      8'h23:   rd_val = r_los;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shift    <= '0;
      ptr      <= '0;
      rbyte    <= '0;
      rnw      <= 1'b0;
      need_ptr <= 1'b0;
      nack     <= 1'b0;
      wr_seen  <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= S_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
      wr_seen <= 1'b0;
    end else if (load_rd) begin
      rbyte  <= rd_val;
      ptr    <= ptr + 8'd1;
      sda_oe <= ~rd_val[7];
      bitcnt <= '0;
      state  <= S_RDAT;
    end else begin
      case (state)
        S_ADDR, S_WDAT: begin
          if (scl_rise) begin
            shift  <= {shift[6:0], sda_q[1]};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (shift[7:1] == DEV_ADDR) begin
                rnw      <= shift[0];
                need_ptr <= ~shift[0];
                sda_oe   <= 1'b1;
                state    <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              if (need_ptr) begin
                ptr      <= shift;
                need_ptr <= 1'b0;
              end else begin
                ptr     <= ptr + 8'd1;
                wr_seen <= 1'b1;
              end
              sda_oe <= 1'b1;
              state  <= S_WACK;
            end
          end
        end
        S_AACK, S_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= S_WDAT;
          end
        end
        S_RDAT: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= S_RACK;
            end else begin
              rbyte  <= {rbyte[6:0], 1'b0};
              sda_oe <= ~rbyte[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack <= sda_q[1];
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {r_g1, r_g2, r_g3, r_u1, r_u2, r_x1, r_x2, r_d1, r_d2, r_misc, r_los} <= '0;
    end else if (soft_rst) begin
      {r_g1, r_g2, r_g3, r_u1, r_u2, r_x1, r_x2, r_d1, r_d2, r_misc, r_los} <= '0;
    end else if (wr_en) begin
      case (ptr)
        8'h0A:   r_g1   <= shift;
        8'h0B:   r_g2   <= shift;
        8'h0C:   r_g3   <= shift;
        8'h10:   r_u1   <= shift;
        8'h11:   r_u2   <= shift;
        8'h12:   r_x1   <= shift;
        8'h13:   r_x2   <= shift;
        8'h20:   r_d1   <= shift;
        8'h21:   r_d2   <= shift;
        8'h22:   r_misc <= shift;
        8'h23:   r_los  <= shift;
        default: ;
      endcase
    end

  logic [1:0]  a_mode;
  logic        a_flip, a_eqov;
  logic [6:0]  a_g3;
  logic [31:0] a_eq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_mode <= '0;
      a_flip <= 1'b0;
      a_eqov <= 1'b0;
      a_g3   <= '0;
      a_eq   <= '0;
    end else if (stop_det && wr_seen) begin
      a_mode <= r_g1[1:0];
      a_flip <= r_g1[2];
      a_eqov <= r_g1[4];
      a_g3   <= r_g3[6:0];
      a_eq   <= {r_d2, r_d1, r_u2, r_u1};
    end

  logic [1:0] pa, pb;

  always_comb begin
    case (a_mode)
      2'd1:    begin pa = L_USB; pb = L_OFF; end
      2'd2:    begin pa = L_VID; pb = L_VID; end
      2'd3:    begin pa = L_USB; pb = L_VID; end
      default: begin pa = L_OFF; pb = L_OFF; end
    endcase
  end

  assign lane_sel_o = a_flip ? {pa, pa, pb, pb} : {pb, pb, pa, pa};
  assign flip_o     = a_flip;
  assign swing_o    = a_g3[6] ? a_g3[5:2] : strap_swing_i;
  assign role_o     = a_g3[1:0];
  assign eq_o       = a_eqov ? a_eq : {{4{strap_deq_i}}, {4{strap_ueq_i}}};

endmodule

// File: rtl/tc_lane_ctrl_chk.sv
module tc_lane_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       stop_det,
  input logic       soft_rst,
  input logic       sda_oe,
  input logic [7:0] lane_sel_o,
  input logic       flip_o,
  input logic [7:0] r_g1,
  input logic [7:0] r_g3
);

  AST_LANES_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lane_sel_o) |-> $past(stop_det)); // R9

  AST_FLIP_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flip_o) |-> $past(stop_det)); // R5

  AST_NO_BAD_LANE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sel_o[1:0] != 2'd3) && (lane_sel_o[3:2] != 2'd3) &&
    (lane_sel_o[5:4] != 2'd3) && (lane_sel_o[7:6] != 2'd3)); // R4

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (r_g1 == 8'h00 && r_g3 == 8'h00)); // R8

  AST_SDA_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R1

endmodule

bind tc_lane_ctrl tc_lane_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_fall   (scl_fall),
  .stop_det   (stop_det),
  .soft_rst   (soft_rst),
  .sda_oe     (sda_oe),
  .lane_sel_o (lane_sel_o),
  .flip_o     (flip_o),
  .r_g1       (r_g1),
  .r_g3       (r_g3)
);

// File: tb/tb_tc_lane_ctrl.sv
module tb_tc_lane_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [3:0] st_sw = 4'h9, st_ue = 4'h2, st_de = 4'hC;
  logic sda_oe, flip;
  logic [7:0] lane;
  logic [3:0] swing;
  logic [1:0] role;
  logic [31:0] eq;
  wire sda_line = sda_m & ~sda_oe;

  tc_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_swing_i(st_sw), .strap_ueq_i(st_ue), .strap_deq_i(st_de),
    .lane_sel_o(lane), .flip_o(flip), .swing_o(swing), .role_o(role), .eq_o(eq));

  int tests = 0, fails = 0;
  logic [7:0] m [256];
  logic [7:0] ap_g1 = 0, ap_g3 = 0;
  logic [31:0] ap_eq = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hq; repeat (4) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1; hq; scl = 1; hq; sda_m = 0; hq; scl = 0; hq;
  endtask

  task automatic i2c_stop;
    sda_m = 0; hq; scl = 1; hq; sda_m = 1; hq; hq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq; scl = 1; hq; hq; scl = 0; hq;
    end
    sda_m = 1; hq; scl = 1; hq; ack = ~sda_line; hq; scl = 0; hq;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hq; scl = 1; hq; b = {b[6:0], sda_line}; hq; scl = 0;
    end
    hq; sda_m = ~ack; hq; scl = 1; hq; hq; scl = 0; hq; sda_m = 1;
  endtask

  function automatic logic [7:0] exp_lane(input logic [1:0] mode, input logic fl);
    logic [1:0] a, b;
    case (mode)
      2'd1: begin a = 1; b = 0; end
      2'd2: begin a = 2; b = 2; end
      2'd3: begin a = 1; b = 2; end
      default: begin a = 0; b = 0; end
    endcase
    return fl ? {a, a, b, b} : {b, b, a, a};
  endfunction

  function automatic logic isdef(input logic [7:0] p);
    return p inside {8'h0A, 8'h0B, 8'h0C, 8'h10, 8'h11, 8'h12, 8'h13, 8'h20, 8'h21, 8'h22, 8'h23};
  endfunction

  task automatic mwrite(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'h1B) begin
      if (d[0]) for (int i = 0; i < 256; i++) m[i] = 8'h00;
    end else if (isdef(p)) m[p] = d;
  endtask

  task automatic apply;
    ap_g1 = m[8'h0A]; ap_g3 = m[8'h0C];
    ap_eq = {m[8'h21], m[8'h20], m[8'h11], m[8'h10]};
  endtask

  task automatic check_outs(input string tag);
    chk({"R4 lanes ", tag}, lane, exp_lane(ap_g1[1:0], ap_g1[2]));
    chk({"R5 flip ", tag}, flip, ap_g1[2]);
    chk({"R6 eq ", tag}, eq, ap_g1[4] ? ap_eq : {{4{st_de}}, {4{st_ue}}});
    chk({"R7 swing ", tag}, swing, ap_g3[6] ? ap_g3[5:2] : st_sw);
    chk({"R7 role ", tag}, role, ap_g3[1:0]);
  endtask

  task automatic wr_nostop(input logic [6:0] a, input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] q;
    q = p;
    i2c_start;
    send_byte({a, 1'b0}, ack);
    chk("R1 address ack", ack, a == 7'h12);
    if (ack) begin
      send_byte(p, ack);
      chk("R1 pointer ack", ack, 1);
      for (int i = 0; i < n; i++) begin
        send_byte(wbuf[i], ack);
        chk("R3 data ack", ack, 1);
        mwrite(q, wbuf[i]);
        q = q + 8'd1;
      end
    end
  endtask

  task automatic wr(input logic [7:0] p, input int n);
    wr_nostop(7'h12, p, n);
    i2c_stop;
    if (n > 0) apply;
  endtask

  task automatic rd(input logic [7:0] p, input int n);
    logic ack;
    logic [7:0] q;
    q = p;
    wr_nostop(7'h12, p, 0);
    i2c_start;
    send_byte({7'h12, 1'b1}, ack);
    chk("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    i2c_stop;
    for (int i = 0; i < n; i++) begin
      chk($sformatf("R2 R3 readback at %h", q), rbuf[i], m[q]);
      q = q + 8'd1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_outs("R10 reset");
    rd(8'h0A, 3);
    rd(8'h10, 4);
    rd(8'h20, 4);

    i2c_start; send_byte({7'h13, 1'b0}, ack); i2c_stop;
    chk("R1 foreign address nack", ack, 0);
    wbuf[0] = 8'h13;
    wr_nostop(7'h13, 8'h0A, 0); i2c_stop;
    check_outs("R1 foreign no effect");

    for (int md = 0; md < 4; md++)
      for (int fl = 0; fl < 2; fl++) begin
        wbuf[0] = 8'h10 | 8'(fl << 2) | 8'(md);
        wr_nostop(7'h12, 8'h0A, 1);
        repeat (6) @(negedge clk);
        chk("R9 lanes held before stop", lane, exp_lane(ap_g1[1:0], ap_g1[2]));
        i2c_stop; apply;
        check_outs("R4 R5 mode sweep");
      end

    wbuf[0] = 8'h55; wbuf[1] = 8'h66; wr(8'h10, 2);
    check_outs("R2 R6 eq pair");
    rd(8'h10, 2);
    wbuf[0] = 8'h33; wbuf[1] = 8'h3C; wr(8'h20, 2);
    check_outs("R6 eq override on");
    wbuf[0] = 8'h03; wr(8'h0A, 1);
    check_outs("R6 eq straps");
    wbuf[0] = 8'h58; wr(8'h0C, 1);
    check_outs("R7 swing override");
    wbuf[0] = 8'h1B; wr(8'h0C, 1);
    check_outs("R7 swing strap role 3");

    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'h7E; wr(8'h0E, 3);
    rd(8'h0E, 3);
    wbuf[0] = 8'hAA; wr(8'h30, 1);
    rd(8'h30, 1);
    wbuf[0] = 8'hFE; wr(8'h1B, 1);
    rd(8'h1B, 1);
    rd(8'h0A, 3);

    wbuf[0] = 8'h01; wr(8'h1B, 1);
    check_outs("R8 soft reset outputs");
    rd(8'h0A, 3); rd(8'h10, 2); rd(8'h20, 2);

    st_sw = 4'h5; st_ue = 4'hA; st_de = 4'h1;
    repeat (3) @(negedge clk);
    check_outs("R6 R7 strap change");

    for (int it = 0; it < 30; it++) begin
      logic [7:0] p;
      int n;
      case ($urandom_range(0, 7))
        0: p = 8'h0A; 1: p = 8'h0C; 2: p = 8'h10; 3: p = 8'h20;
        4: p = 8'h12; 5: p = 8'h22; 6: p = 8'h09;
        default: p = ($urandom_range(0, 9) == 0) ? 8'h1B : 8'h0B;
      endcase
      n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr(p, n);
      check_outs("random");
      rd(p, n);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule